// File: doc/BRIEF.md
# Carry-Free Signed-Digit Adder

This block adds two numbers held in a redundant binary signed-digit form and returns their sum in that same form. Each digit takes two bits, and its value is the high bit plus the low bit minus one. So `00` is −1, `11` is +1, and both `01` and `10` mean zero. The block is purely combinational. Its result width does not lengthen any carry path: each output digit is settled from a small window of operand digits at and just below its own position.

There are two operand modes, chosen by `mode_tc`. In one mode the first operand is a signed-digit word and the second is a second signed-digit word. In the other mode the second operand is an ordinary two's-complement word, and each of its bits is taken directly as a digit, with no conversion beforehand. The result has one digit more than the operands, so every sum is representable. Converting the result back to binary is left to the consumer.

Top module: `bsd_adder`

## Requirements
- R1: On every input digit of `op_a` and `op_b_sd`, code `00` counts as −1, `11` as +1, and both `01` and `10` count as 0; input digit i has weight 2^i.
- R2: With `mode_tc` = 1, the second operand is `op_b_tc` read as a DIGITS-bit two's-complement number: bit i (i < DIGITS−1) is a digit of value 0 or 1 with weight 2^i, and the top bit is a digit of value 0 or −1 with weight 2^(DIGITS−1). With `mode_tc` = 0, the second operand is the signed-digit word `op_b_sd`.
- R3: `sum` holds DIGITS+1 digits (digit i at bits [2i+1:2i]), and its value equals the value of `op_a` plus the value of the selected second operand, for every input combination.
- R4: Every output digit is `00` (−1), `01` (0) or `11` (+1); the code `10` never appears on `sum`.
- R5: The operand that the mode does not select has no effect: `op_b_tc` is ignored when `mode_tc` = 0, and `op_b_sd` is ignored when `mode_tc` = 1.
- R6: Output digit i depends only on operand digits at positions i, i−1 and i−2, so changing operand digit j can change only output digits j, j+1 and j+2.
- R7: When every operand digit is zero, whichever zero code it uses, every output digit is `01`.
- R8: The top output digit (bits [2·DIGITS+1:2·DIGITS]) is `11` whenever the true sum is at least 2^DIGITS, and `00` whenever it is at most −2^DIGITS.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_a | input | 2*DIGITS | First operand, signed-digit code, digit i at bits [2i+1:2i] |
| op_b_sd | input | 2*DIGITS | Second operand in signed-digit code, used when `mode_tc` = 0 |
| op_b_tc | input | DIGITS | Second operand in two's complement, used when `mode_tc` = 1 |
| mode_tc | input | 1 | Operand mode: 0 for signed-digit plus signed-digit, 1 for signed-digit plus two's complement |
| sum | output | 2*(DIGITS+1) | Result in signed-digit code, DIGITS+1 digits |

## Verification
On every evaluation, the assertions decode the ports to integers and confirm that the sum's value is exact. They also confirm that the forbidden output code `10` never appears, that all-zero operands give canonical zero digits, and that the top digit takes the only sign a large sum allows. Other properties compare two different input sets, so only the bench scenarios can show them: that the unselected operand is ignored, and that a change to one digit disturbs no output digit outside the three-position window. The bench also feeds operands in both zero codes, in both modes, and at the extremes of range.

// File: rtl/bsd_adder.sv
module bsd_adder #(
  parameter int DIGITS = 16
) (
  input  logic [2*DIGITS-1:0]   op_a,
  input  logic [2*DIGITS-1:0]   op_b_sd,
  input  logic [DIGITS-1:0]     op_b_tc,
  input  logic                  mode_tc,
  output logic [2*DIGITS+1:0]   sum
);
  localparam int OW = DIGITS + 1;

  function automatic logic signed [2:0] dig_val(input logic [1:0] c);
    return $signed({2'b00, c[1]}) + $signed({2'b00, c[0]}) - 3'sd1;
  endfunction

  function automatic logic [1:0] dig_code(input logic signed [2:0] v);
    if (v < 3'sd0)      return 2'b00;
    else if (v > 3'sd0) return 2'b11;
    else                return 2'b01;
  endfunction

  logic signed [2:0] pos_sum [DIGITS];
  logic signed [2:0] xfer    [OW];

  assign xfer[0] = 3'sd0;

  for (genvar i = 0; i < DIGITS; i++) begin : g_dig
    logic signed [2:0] da, db, t_out, w_loc;
    logic              low_nonneg;

    assign da = dig_val(op_a[2*i +: 2]);

    if (i == DIGITS - 1) begin : g_sign
      assign db = mode_tc ? (op_b_tc[i] ? -3'sd1 : 3'sd0) : dig_val(op_b_sd[2*i +: 2]);
    end else begin : g_mag
      assign db = mode_tc ? (op_b_tc[i] ? 3'sd1 : 3'sd0) : dig_val(op_b_sd[2*i +: 2]);
    end

    assign pos_sum[i] = da + db;

    if (i == 0) begin : g_base
      assign low_nonneg = 1'b1;
    end else begin : g_chain
      assign low_nonneg = (pos_sum[i-1] >= 3'sd0);
    end

    always_comb begin
      t_out = 3'sd0;
      w_loc = 3'sd0;
      case (pos_sum[i])
        3'sd2:  t_out = 3'sd1;
        -3'sd2: t_out = -3'sd1;
        3'sd1: begin
          if (low_nonneg) begin t_out = 3'sd1; w_loc = -3'sd1; end
          else            begin t_out = 3'sd0; w_loc = 3'sd1;  end
        end
        -3'sd1: begin
          if (low_nonneg) begin t_out = 3'sd0;  w_loc = -3'sd1; end
          else            begin t_out = -3'sd1; w_loc = 3'sd1;  end
        end
        default: begin t_out = 3'sd0; w_loc = 3'sd0; end
      endcase
    end

    assign xfer[i+1] = t_out;
    assign sum[2*i +: 2] = dig_code(w_loc + xfer[i]);
  end

  assign sum[2*DIGITS +: 2] = dig_code(xfer[DIGITS]);

  function automatic longint word_val(input logic [2*OW-1:0] w);
    longint acc = 0;
    for (int k = 0; k < OW; k++)
      acc += longint'(dig_val(w[2*k +: 2])) <<< k;
    return acc;
  endfunction

  longint chk_a, chk_b, chk_s;
  logic   all_zero_in;

  always_comb begin
    chk_a = word_val({2'b01, op_a});
    chk_b = mode_tc ? longint'($signed(op_b_tc)) : word_val({2'b01, op_b_sd});
    chk_s = word_val(sum);
    all_zero_in = 1'b1;
    for (int k = 0; k < DIGITS; k++) begin
      if (op_a[2*k +: 2] == 2'b00 || op_a[2*k +: 2] == 2'b11) all_zero_in = 1'b0;
      if (mode_tc ? op_b_tc[k] : (op_b_sd[2*k +: 2] == 2'b00 || op_b_sd[2*k +: 2] == 2'b11))
        all_zero_in = 1'b0;
    end
    a_r3_sum_value: assert (chk_s == chk_a + chk_b);
    for (int k = 0; k < OW; k++)
      a_r4_no_alt_zero: assert (sum[2*k +: 2] != 2'b10);
    if (all_zero_in)
      a_r7_zero_canon: assert (sum == {OW{2'b01}});
    if (chk_a + chk_b >= (longint'(1) <<< DIGITS))
      a_r8_top_pos: assert (sum[2*DIGITS +: 2] == 2'b11);
    if (chk_a + chk_b <= -(longint'(1) <<< DIGITS))
      a_r8_top_neg: assert (sum[2*DIGITS +: 2] == 2'b00);
  end
endmodule

// File: tb/sim_bsd_adder.sv
`timescale 1ns/1ps
module sim_bsd_adder;
  localparam int N  = 16;
  localparam int OW = N + 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic [2*N-1:0]  op_a, op_b_sd;
  logic [N-1:0]    op_b_tc;
  logic            mode_tc;
  logic [2*OW-1:0] sum;

  int checks = 0;
  int failures = 0;

  bsd_adder #(.DIGITS(N)) u0 (
    .op_a(op_a), .op_b_sd(op_b_sd), .op_b_tc(op_b_tc), .mode_tc(mode_tc), .sum(sum)
  );

  localparam int NV = 8;
  localparam longint VA [NV] = '{0, 5, -7, 1000, -1, 65535, -65535, 12345};
  localparam longint VB [NV] = '{0, 3, 12, -1000, -1, -32768, -65535, 32767};
  localparam bit     VM [NV] = '{1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1};

  function automatic longint dec(input logic [2*OW-1:0] w);
    longint acc = 0;
    for (int k = 0; k < OW; k++) begin
      case (w[2*k +: 2])
        2'b00:   acc -= (longint'(1) <<< k);
        2'b11:   acc += (longint'(1) <<< k);
        default: ;
      endcase
    end
    return acc;
  endfunction

  function automatic logic [2*N-1:0] enc(input longint v, input bit alt_zero);
    logic [2*N-1:0] w;
    longint m = (v < 0) ? -v : v;
    for (int k = 0; k < N; k++) begin
      if (m[k]) w[2*k +: 2] = (v < 0) ? 2'b00 : 2'b11;
      else      w[2*k +: 2] = alt_zero ? 2'b10 : 2'b01;
    end
    return w;
  endfunction

  function automatic bit has_alt(input logic [2*OW-1:0] w);
    for (int k = 0; k < OW; k++)
      if (w[2*k +: 2] == 2'b10) return 1'b1;
    return 1'b0;
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic settle();
    @(posedge clk);
    #2;
  endtask

  task automatic drive(input logic [2*N-1:0] a, input logic [2*N-1:0] bs,
                       input logic [N-1:0] bt, input logic m);
    @(negedge clk);
    op_a = a; op_b_sd = bs; op_b_tc = bt; mode_tc = m;
    settle();
  endtask

  initial begin
    #(200000 * 8);
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [2*OW-1:0] ref_sum, new_sum;
    longint e;
    op_a = '0; op_b_sd = '0; op_b_tc = '0; mode_tc = 1'b0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;

    // R7: all-zero operands in both zero codes give canonical zeros
    drive({N{2'b01}}, {N{2'b10}}, '0, 1'b0);
    chk(sum == {OW{2'b01}}, "R7 zero codes", dec(sum), 0);
    drive({N{2'b10}}, {N{2'b01}}, '0, 1'b1);
    chk(sum == {OW{2'b01}}, "R7 zero in tc mode", dec(sum), 0);

    // R1 R3: table of vectors, alternating the zero code used
    for (int v = 0; v < NV; v++) begin
      e = VA[v] + VB[v];
      drive(enc(VA[v], v[0]), enc(VM[v] ? 0 : VB[v], !v[0]),
            VM[v] ? VB[v][N-1:0] : 16'h0, VM[v]);
      chk(dec(sum) == e, "R1 R3 table vector", dec(sum), e);
      chk(!has_alt(sum), "R4 table output code", 1, 0);
    end

    // R2: sign bit weight of the two's-complement operand
    drive(enc(0, 1'b1), '0, 16'hFFFF, 1'b1);
    chk(dec(sum) == -1, "R2 tc all ones", dec(sum), -1);
    drive(enc(0, 1'b0), '0, 16'h8000, 1'b1);
    chk(dec(sum) == -32768, "R2 tc sign only", dec(sum), -32768);

    // R8: top digit at extremes
    drive({N{2'b11}}, {N{2'b11}}, '0, 1'b0);
    chk(sum[2*N +: 2] == 2'b11, "R8 top +1 sd", sum[2*N +: 2], 3);
    drive({N{2'b00}}, {N{2'b00}}, '0, 1'b0);
    chk(sum[2*N +: 2] == 2'b00, "R8 top -1 sd", sum[2*N +: 2], 0);
    drive({N{2'b11}}, '0, 16'h7FFF, 1'b1);
    chk(sum[2*N +: 2] == 2'b11, "R8 top +1 tc", sum[2*N +: 2], 3);
    drive({N{2'b00}}, '0, 16'h8000, 1'b1);
    chk(sum[2*N +: 2] == 2'b00, "R8 top -1 tc", sum[2*N +: 2], 0);

    // R5: unselected operand is ignored
    drive(enc(1234, 1'b0), enc(-77, 1'b1), 16'h1111, 1'b0);
    ref_sum = sum;
    drive(enc(1234, 1'b0), enc(-77, 1'b1), 16'hBEEF, 1'b0);
    chk(sum == ref_sum, "R5 op_b_tc ignored", dec(sum), dec(ref_sum));
    drive(enc(1234, 1'b0), enc(500, 1'b0), 16'h0042, 1'b1);
    ref_sum = sum;
    drive(enc(1234, 1'b0), {N{2'b00}}, 16'h0042, 1'b1);
    chk(sum == ref_sum, "R5 op_b_sd ignored", dec(sum), dec(ref_sum));

    // R6: one changed digit only reaches three output positions
    foreach (VA[j]) begin
      int pos;
      logic [2*N-1:0] a0, b0;
      bit same;
      pos = (j * 5) % N;
      a0 = {$urandom, $urandom} & {N{2'b11}};
      b0 = {$urandom, $urandom} & {N{2'b11}};
      a0[2*pos +: 2] = 2'b00;
      drive(a0, b0, '0, 1'b0);
      ref_sum = sum;
      a0[2*pos +: 2] = 2'b11;
      drive(a0, b0, '0, 1'b0);
      new_sum = sum;
      same = 1'b1;
      for (int k = 0; k < OW; k++)
        if ((k < pos || k > pos + 2) && new_sum[2*k +: 2] != ref_sum[2*k +: 2]) same = 1'b0;
      chk(same, "R6 locality", pos, pos);
    end

    // R3 R4: random operands with all four digit codes
    for (int r = 0; r < 300; r++) begin
      logic [2*N-1:0] a0, b0;
      logic [N-1:0] t0;
      logic m0;
      a0 = {$urandom, $urandom};
      b0 = {$urandom, $urandom};
      t0 = N'($urandom);
      m0 = r[0];
      e = dec({2'b01, a0}) + (m0 ? longint'($signed(t0)) : dec({2'b01, b0}));
      drive(a0, b0, t0, m0);
      chk(dec(sum) == e, "R3 random sum", dec(sum), e);
      chk(!has_alt(sum), "R4 random output code", 1, 0);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule